// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel Controller

This block sequences one DMA channel. Software writes a mode word, loads four direct registers (PCI address, local address, byte count and link word), then writes a command byte that sets enable and start. With chaining on, the controller reads four-word descriptors one word at a time through a memory request port. The descriptors can sit in either of two address spaces. After each descriptor is read, the controller asks an abstract data mover for one transfer and then follows the link word to the next descriptor. With chaining off, it issues a single transfer straight from the direct registers and reads no memory.

The link word does two jobs. It gives the 16-byte-aligned address of the next descriptor, and its low four bits are per-descriptor flags. One flag sets the space of the next descriptor, one ends the chain, one asks for an interrupt when this descriptor's count has been moved, and one sets the transfer direction. A single sticky interrupt flag collects the terminal-count and done events. A mode bit sends that flag to the PCI-side or the local-side interrupt pin. An abort lets the handshake in flight finish, then stops the channel without reading any more descriptors.

Top module: `sgdma_chain_engine`

## Requirements
- R1: In chained mode each descriptor is read as four 32-bit words at byte offsets +0, +4, +8 and +12, in this order: PCI address, local address, byte count, link word. The transfer request then carries the PCI address, the local address and the count from those words.
- R2: The first descriptor address is taken from bits 31:4 of the direct link register (low four bits zero). Each next descriptor address is taken from bits 31:4 of the current link word. Bit 0 of the link (or of the direct link register, for the first descriptor) set to 1 places that next descriptor in PCI space (`mem_pci`=1); set to 0 places it in local space.
- R3: Link bit 1 ends the chain after the current descriptor. Link bit 3 set to 1 selects local-to-PCI direction (`xfer_l2p`=1); set to 0 selects PCI-to-local.
- R4: Only bits 22:0 of the count word reach `xfer_count`.
- R5: In the command byte, bit 0 is enable and is stored from every command write. Bit 1 is start, a write-1 action. Start begins a run only when bit 0 is also 1 in the same write and the channel is idle. Otherwise it has no effect.
- R6: The status byte shows enable at bit 0 and done at bit 4, and every other bit reads 0. Done is 1 after reset and whenever the channel is idle. It is 0 from the clock edge that accepts a start until the run ends.
- R7: With mode bit 16 set, after each chained transfer the controller writes the descriptor's count word back (offset +8) with bits 22:0 cleared. With mode bit 16 clear, descriptor memory is never written.
- R8: With mode bit 9 clear, a start produces exactly one transfer from the direct PCI address, local address and count registers, with direction from bit 3 and interrupt request from bit 2 of the direct link register. No memory access takes place.
- R9: A completed transfer whose link bit 2 is set, or the end of a run while mode bit 10 is set, sets one sticky interrupt flag. The flag stays set until a command write has bit 3 set.
- R10: With mode bit 17 set the flag drives `irq_pci`; with it clear the flag drives `irq_local`. The two outputs are never both high.
- R11: A command write with bit 2 set during a run lets the memory or mover handshake in flight complete. The channel then returns to idle, with done at 1 and no further descriptor reads or transfers. An abort written while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Command byte write strobe |
| csr_wdata | input | 8 | Command byte: enable, start, abort, clear-interrupt |
| csr_status | output | 8 | Status byte: enable (bit 0), done (bit 4) |
| mode_we | input | 1 | Mode word write strobe |
| mode_wdata | input | 32 | Mode word: chain (9), done-irq (10), clear-count (16), PCI irq (17) |
| dir_we | input | 1 | Direct register write strobe |
| dir_sel | input | 2 | Direct register select: 0 PCI addr, 1 local addr, 2 count, 3 link |
| dir_wdata | input | 32 | Direct register write data |
| mem_req | output | 1 | Descriptor memory request, held until acknowledge |
| mem_we | output | 1 | Request is a count write-back |
| mem_pci | output | 1 | Request targets PCI space (1) or local space (0) |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| mem_rdata | input | 32 | Read data, valid with acknowledge |
| xfer_req | output | 1 | Transfer request to the mover, held until acknowledge |
| xfer_l2p | output | 1 | Direction: 1 local-to-PCI |
| xfer_pci_addr | output | 32 | PCI start address |
| xfer_loc_addr | output | 32 | Local start address |
| xfer_count | output | 23 | Byte count |
| xfer_ack | input | 1 | Mover acknowledge, one cycle |
| irq_pci | output | 1 | Channel interrupt, PCI side |
| irq_local | output | 1 | Channel interrupt, local side |

## Verification
The main function is driven with three chain shapes. The first is a single direct transfer with an oversized count, which separates direct-register use from memory fetch and shows the count mask. The second is a three-descriptor chain that hops local→PCI→local with mixed direction and interrupt flags; it separates correct word order, space selection and link following from off-by-one offsets, and shows that the chain stops at the end mark. The same chain is run again with count clearing, which tells write-back from a read-only walk. A slow mover is used to see busy status and an ignored second start, and an abort placed during the first transfer must leave exactly one transfer and one descriptor read.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;
   // command/status byte bit positions
   localparam int CSR_EN   = 0;
   localparam int CSR_GO   = 1;
   localparam int CSR_ABT  = 2;
   localparam int CSR_CLRI = 3;
   localparam int CSR_DONE = 4;
   // mode word bit positions
   localparam int MD_CHAIN  = 9;
   localparam int MD_DONEIE = 10;
   localparam int MD_CLRCNT = 16;
   localparam int MD_PCIIRQ = 17;
   // link word flag positions
   localparam int NX_PCI = 0;
   localparam int NX_EOC = 1;
   localparam int NX_TCI = 2;
   localparam int NX_L2P = 3;
   // descriptor word order
   localparam int W_PADR = 0;
   localparam int W_LADR = 1;
   localparam int W_CNT  = 2;
   localparam int W_LINK = 3;
   localparam int N_WORDS = 4;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_FETCH,
      ST_MOVE,
      ST_WBACK
   } walk_st_t;
endpackage

// File: rtl/sgdma_ctl.sv
module sgdma_ctl
   import sgdma_pkg::*;
#(
   parameter bit IRQ_ROUTE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        csr_we,
   input  logic [7:0]  csr_wdata,
   input  logic        mode_we,
   input  logic [31:0] mode_wdata,
   input  logic        busy,
   input  logic        finish,
   input  logic        tc_hit,
   output logic        start_go,
   output logic        abort_go,
   output logic        chain_en,
   output logic        clrcnt_en,
   output logic [7:0]  csr_status,
   output logic        irq_pci,
   output logic        irq_local
);
   logic en_q, chain_q, doneie_q, clrcnt_q, pciirq_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         chain_q  <= 1'b0;
         doneie_q <= 1'b0;
         clrcnt_q <= 1'b0;
         pciirq_q <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         if (csr_we) en_q <= csr_wdata[CSR_EN];
         if (mode_we) begin
            chain_q  <= mode_wdata[MD_CHAIN];
            doneie_q <= mode_wdata[MD_DONEIE];
            clrcnt_q <= mode_wdata[MD_CLRCNT];
            pciirq_q <= mode_wdata[MD_PCIIRQ];
         end
         // a new event wins over a clear in the same cycle
         if (tc_hit || (finish && doneie_q)) irq_q <= 1'b1;
         else if (csr_we && csr_wdata[CSR_CLRI]) irq_q <= 1'b0;
      end
   end

   assign start_go  = csr_we && csr_wdata[CSR_GO] && csr_wdata[CSR_EN] && !busy;
   assign abort_go  = csr_we && csr_wdata[CSR_ABT];
   assign chain_en  = chain_q;
   assign clrcnt_en = clrcnt_q;

   always_comb begin
      csr_status           = '0;
      csr_status[CSR_EN]   = en_q;
      csr_status[CSR_DONE] = !busy;
   end

   generate
      if (IRQ_ROUTE) begin : g_route
         assign irq_pci   = irq_q && pciirq_q;
         assign irq_local = irq_q && !pciirq_q;
      end else begin : g_local_only
         assign irq_pci   = 1'b0;
         assign irq_local = irq_q;
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^{csr_wdata[7:4], mode_wdata};
endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
   import sgdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int DW = 32,
   parameter int CW = 23
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_go,
   input  logic          abort_go,
   input  logic          chain_en,
   input  logic          clrcnt_en,
   input  logic [DW-1:0] dir_padr,
   input  logic [DW-1:0] dir_ladr,
   input  logic [DW-1:0] dir_cnt,
   input  logic [DW-1:0] dir_link,
   output logic          busy,
   output logic          finish,
   output logic          tc_hit,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_pci,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          xfer_req,
   output logic          xfer_l2p,
   output logic [AW-1:0] xfer_pci_addr,
   output logic [AW-1:0] xfer_loc_addr,
   output logic [CW-1:0] xfer_count,
   input  logic          xfer_ack
);
   localparam int IW = $clog2(N_WORDS);
   localparam int CNT_OFS = W_CNT * (DW / 8);

   walk_st_t st_q, st_d;
   logic [IW-1:0] idx_q, idx_d;
   logic [AW-1:0] cur_q, cur_d;
   logic          pci_q, pci_d;
   logic          abort_q, aborting, load_direct;
   logic [N_WORDS-1:0][DW-1:0] dword_q;
   logic [DW-1:0] link;

   assign link     = dword_q[W_LINK];
   assign aborting = abort_q || abort_go;

   always_comb begin
      st_d  = st_q;
      idx_d = idx_q;
      cur_d = cur_q;
      pci_d = pci_q;
      unique case (st_q)
         ST_IDLE: if (start_go) begin
            if (chain_en) begin
               st_d  = ST_FETCH;
               idx_d = '0;
               cur_d = {dir_link[AW-1:4], 4'b0000};
               pci_d = dir_link[NX_PCI];
            end else begin
               st_d = ST_MOVE;
            end
         end
         ST_FETCH: if (mem_ack) begin
            if (aborting) st_d = ST_IDLE;
            else if (idx_q == IW'(N_WORDS - 1)) st_d = ST_MOVE;
            else idx_d = idx_q + 1'b1;
         end
         ST_MOVE: if (xfer_ack) begin
            if (aborting || !chain_en) st_d = ST_IDLE;
            else if (clrcnt_en) st_d = ST_WBACK;
            else if (link[NX_EOC]) st_d = ST_IDLE;
            else begin
               st_d  = ST_FETCH;
               idx_d = '0;
               cur_d = {link[AW-1:4], 4'b0000};
               pci_d = link[NX_PCI];
            end
         end
         ST_WBACK: if (mem_ack) begin
            if (aborting || link[NX_EOC]) st_d = ST_IDLE;
            else begin
               st_d  = ST_FETCH;
               idx_d = '0;
               cur_d = {link[AW-1:4], 4'b0000};
               pci_d = link[NX_PCI];
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   assign load_direct = (st_q == ST_IDLE) && start_go && !chain_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         idx_q   <= '0;
         cur_q   <= '0;
         pci_q   <= 1'b0;
         abort_q <= 1'b0;
         dword_q <= '0;
      end else begin
         st_q  <= st_d;
         idx_q <= idx_d;
         cur_q <= cur_d;
         pci_q <= pci_d;
         if (st_q == ST_IDLE) abort_q <= 1'b0;
         else if (abort_go) abort_q <= 1'b1;
         if (load_direct) dword_q <= {dir_link, dir_cnt, dir_ladr, dir_padr};
         else if (st_q == ST_FETCH && mem_ack) dword_q[idx_q] <= mem_rdata;
      end
   end

   assign busy   = (st_q != ST_IDLE);
   assign finish = busy && (st_d == ST_IDLE);
   assign tc_hit = (st_q == ST_MOVE) && xfer_ack && link[NX_TCI];

   assign mem_req   = (st_q == ST_FETCH) || (st_q == ST_WBACK);
   assign mem_we    = (st_q == ST_WBACK);
   assign mem_pci   = pci_q;
   assign mem_addr  = (st_q == ST_WBACK) ? cur_q + AW'(CNT_OFS)
                                         : cur_q + AW'({idx_q, 2'b00});
   assign mem_wdata = {dword_q[W_CNT][DW-1:CW], {CW{1'b0}}};

   assign xfer_req      = (st_q == ST_MOVE);
   assign xfer_l2p      = link[NX_L2P];
   assign xfer_pci_addr = dword_q[W_PADR][AW-1:0];
   assign xfer_loc_addr = dword_q[W_LADR][AW-1:0];
   assign xfer_count    = dword_q[W_CNT][CW-1:0];
endmodule

// File: rtl/sgdma_chain_engine.sv
module sgdma_chain_engine
   import sgdma_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int CW        = 23,
   parameter bit IRQ_ROUTE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          csr_we,
   input  logic [7:0]    csr_wdata,
   output logic [7:0]    csr_status,
   input  logic          mode_we,
   input  logic [31:0]   mode_wdata,
   input  logic          dir_we,
   input  logic [1:0]    dir_sel,
   input  logic [DW-1:0] dir_wdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic          mem_pci,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata,
   output logic          xfer_req,
   output logic          xfer_l2p,
   output logic [AW-1:0] xfer_pci_addr,
   output logic [AW-1:0] xfer_loc_addr,
   output logic [CW-1:0] xfer_count,
   input  logic          xfer_ack,
   output logic          irq_pci,
   output logic          irq_local
);
   generate
      if (DW != 32) begin : g_bad_dw
         $error("descriptor words must be 32 bits");
      end
      if (AW < 5 || AW > DW) begin : g_bad_aw
         $error("address width must lie in 5..DW");
      end
      if (CW < 1 || CW >= DW) begin : g_bad_cw
         $error("count width must lie in 1..DW-1");
      end
   endgenerate

   logic [DW-1:0] dir_padr_q, dir_ladr_q, dir_cnt_q, dir_link_q;
   logic busy, finish, tc_hit, start_go, abort_go, chain_en, clrcnt_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_padr_q <= '0;
         dir_ladr_q <= '0;
         dir_cnt_q  <= '0;
         dir_link_q <= '0;
      end else if (dir_we) begin
         unique case (dir_sel)
            2'd0: dir_padr_q <= dir_wdata;
            2'd1: dir_ladr_q <= dir_wdata;
            2'd2: dir_cnt_q  <= dir_wdata;
            default: dir_link_q <= dir_wdata;
         endcase
      end
   end

   sgdma_ctl #(.IRQ_ROUTE(IRQ_ROUTE)) u_ctl (
      .clk(clk), .rst_n(rst_n),
      .csr_we(csr_we), .csr_wdata(csr_wdata),
      .mode_we(mode_we), .mode_wdata(mode_wdata),
      .busy(busy), .finish(finish), .tc_hit(tc_hit),
      .start_go(start_go), .abort_go(abort_go),
      .chain_en(chain_en), .clrcnt_en(clrcnt_en),
      .csr_status(csr_status),
      .irq_pci(irq_pci), .irq_local(irq_local)
   );

   sgdma_walker #(.AW(AW), .DW(DW), .CW(CW)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .start_go(start_go), .abort_go(abort_go),
      .chain_en(chain_en), .clrcnt_en(clrcnt_en),
      .dir_padr(dir_padr_q), .dir_ladr(dir_ladr_q),
      .dir_cnt(dir_cnt_q), .dir_link(dir_link_q),
      .busy(busy), .finish(finish), .tc_hit(tc_hit),
      .mem_req(mem_req), .mem_we(mem_we), .mem_pci(mem_pci),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .xfer_req(xfer_req), .xfer_l2p(xfer_l2p),
      .xfer_pci_addr(xfer_pci_addr), .xfer_loc_addr(xfer_loc_addr),
      .xfer_count(xfer_count), .xfer_ack(xfer_ack)
   );
endmodule

// File: rtl/sgdma_chain_engine_chk.sv
module sgdma_chain_engine_chk #(
   parameter int AW = 32,
   parameter int CW = 23
) (
   input logic          clk,
   input logic          rst_n,
   input logic          csr_we,
   input logic [7:0]    csr_wdata,
   input logic [7:0]    csr_status,
   input logic          mem_req,
   input logic          mem_ack,
   input logic          xfer_req,
   input logic          xfer_ack,
   input logic [AW-1:0] xfer_pci_addr,
   input logic [CW-1:0] xfer_count,
   input logic          irq_pci,
   input logic          irq_local
);
   logic active, abort_seen;
   assign active = mem_req || xfer_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abort_seen <= 1'b0;
      else if (!active) abort_seen <= 1'b0;
      else if (csr_we && csr_wdata[2]) abort_seen <= 1'b1;
   end

   // R6: done reads 1 exactly when no handshake is outstanding
   a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      csr_status[4] == !active);

   // R10: interrupt outputs are exclusive
   a_r10_one_irq_pin: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_pci && irq_local));

   // R1: transfer request and its fields hold until acknowledged
   a_r1_xfer_hold: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req && !xfer_ack |=> xfer_req && $stable(xfer_pci_addr) && $stable(xfer_count));

   // R9: the interrupt flag is sticky until cleared
   a_r9_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_pci || irq_local) && !(csr_we && csr_wdata[3]) |=> (irq_pci || irq_local));

   // R5: activity starts only after a write carrying enable and start
   a_r5_start_gated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> $past(csr_we && csr_wdata[0] && csr_wdata[1]));

   // R11: after an abort the next completed handshake ends the run
   a_r11_abort_stops: assert property (@(posedge clk) disable iff (!rst_n)
      abort_seen && (mem_ack || xfer_ack) |=> !active);
endmodule

bind sgdma_chain_engine sgdma_chain_engine_chk #(.AW(AW), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata),
   .csr_status(csr_status), .mem_req(mem_req), .mem_ack(mem_ack),
   .xfer_req(xfer_req), .xfer_ack(xfer_ack), .xfer_pci_addr(xfer_pci_addr),
   .xfer_count(xfer_count), .irq_pci(irq_pci), .irq_local(irq_local)
);

// File: tb/sgdma_chain_engine_tb.sv
`timescale 1ns/1ps
module sgdma_chain_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [7:0]  csr_wdata = '0;
   logic [7:0]  csr_status;
   logic        mode_we = 1'b0;
   logic [31:0] mode_wdata = '0;
   logic        dir_we = 1'b0;
   logic [1:0]  dir_sel = '0;
   logic [31:0] dir_wdata = '0;
   logic        mem_req, mem_we, mem_pci;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        xfer_req, xfer_l2p;
   logic [31:0] xfer_pci_addr, xfer_loc_addr;
   logic [22:0] xfer_count;
   logic        xfer_ack = 1'b0;
   logic        irq_pci, irq_local;

   always #2 clk = ~clk;

   sgdma_chain_engine u_dut (.*);

   int n_chk = 0, n_bad = 0;
   int rd_cnt = 0, wr_cnt = 0, n_xfer = 0, mv_cnt = 0, mv_delay = 0;
   logic [31:0] lmem [64];
   logic [31:0] pmem [64];
   logic [31:0] lg_padr [8];
   logic [31:0] lg_ladr [8];
   logic [31:0] lg_cnt  [8];
   logic        lg_l2p  [8];

   // descriptor memory model, one-cycle acknowledge
   always @(posedge clk) begin
      if (!rst_n) mem_ack <= 1'b0;
      else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            if (mem_pci) pmem[mem_addr[7:2]] = mem_wdata;
            else         lmem[mem_addr[7:2]] = mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= mem_pci ? pmem[mem_addr[7:2]] : lmem[mem_addr[7:2]];
            rd_cnt <= rd_cnt + 1;
         end
      end else mem_ack <= 1'b0;
   end

   // data mover model with programmable latency
   always @(posedge clk) begin
      if (!rst_n) begin
         xfer_ack <= 1'b0;
         mv_cnt   <= 0;
      end else if (xfer_req && !xfer_ack) begin
         if (mv_cnt >= mv_delay) begin
            xfer_ack <= 1'b1;
            mv_cnt   <= 0;
            if (n_xfer < 8) begin
               lg_padr[n_xfer] <= xfer_pci_addr;
               lg_ladr[n_xfer] <= xfer_loc_addr;
               lg_cnt[n_xfer]  <= {9'd0, xfer_count};
               lg_l2p[n_xfer]  <= xfer_l2p;
            end
            n_xfer <= n_xfer + 1;
         end else mv_cnt <= mv_cnt + 1;
      end else xfer_ack <= 1'b0;
   end

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
      end
   endtask

   task automatic csr_write(input logic [7:0] v);
      @(negedge clk); csr_we = 1'b1; csr_wdata = v;
      @(negedge clk); csr_we = 1'b0; csr_wdata = '0;
   endtask

   task automatic mode_write(input logic [31:0] v);
      @(negedge clk); mode_we = 1'b1; mode_wdata = v;
      @(negedge clk); mode_we = 1'b0;
   endtask

   task automatic dir_write(input logic [1:0] s, input logic [31:0] v);
      @(negedge clk); dir_we = 1'b1; dir_sel = s; dir_wdata = v;
      @(negedge clk); dir_we = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 2000; i++) begin
         if (csr_status[4]) break;
         @(negedge clk);
      end
   endtask

   task automatic clear_logs();
      @(negedge clk);
      rd_cnt = 0; wr_cnt = 0; n_xfer = 0;
   endtask

   // chain: local 0x40 -> PCI 0x80 -> local 0xC0 (end)
   task automatic load_chain();
      for (int i = 0; i < 64; i++) begin lmem[i] = '0; pmem[i] = '0; end
      lmem[16] = 32'hA000_0000; lmem[17] = 32'h0000_0A00;
      lmem[18] = 32'h0000_0010; lmem[19] = 32'h0000_0081;
      pmem[32] = 32'hB000_0000; pmem[33] = 32'h0000_0B00;
      pmem[34] = 32'h0000_0020; pmem[35] = 32'h0000_00CC;
      lmem[48] = 32'hC000_0000; lmem[49] = 32'h0000_0C00;
      lmem[50] = 32'h0000_0030; lmem[51] = 32'h0000_00F2;
      dir_write(2'd3, 32'h0000_0040);
   endtask

   task automatic t_reset();
      check("R6 status after reset", {24'd0, csr_status}, 32'h10);
      check("R9 no irq after reset", {30'd0, irq_pci, irq_local}, 0);
      check("R6 no request after reset", {30'd0, mem_req, xfer_req}, 0);
   endtask

   task automatic t_direct();
      mv_delay = 0;
      mode_write(32'h0);
      dir_write(2'd0, 32'h0000_1000);
      dir_write(2'd1, 32'h0000_2000);
      dir_write(2'd2, 32'hFFAB_CDEF);
      dir_write(2'd3, 32'h0000_0008);
      clear_logs();
      csr_write(8'h03);
      wait_idle();
      check("R8 one direct transfer", n_xfer, 1);
      check("R8 direct pci addr", lg_padr[0], 32'h0000_1000);
      check("R8 direct local addr", lg_ladr[0], 32'h0000_2000);
      check("R4 count masked to 23 bits", lg_cnt[0], 32'h002B_CDEF);
      check("R3 direct dir local-to-pci", {31'd0, lg_l2p[0]}, 1);
      check("R8 no memory access", rd_cnt + wr_cnt, 0);
      check("R6 status idle and enabled", {24'd0, csr_status}, 32'h11);
      check("R9 no irq without flags", {30'd0, irq_pci, irq_local}, 0);
   endtask

   task automatic t_no_enable();
      clear_logs();
      csr_write(8'h02);
      repeat (20) @(negedge clk);
      check("R5 start without enable ignored", n_xfer, 0);
      check("R5 status enable cleared", {24'd0, csr_status}, 32'h10);
   endtask

   task automatic t_chain();
      mv_delay = 1;
      mode_write(32'h0000_0200);
      load_chain();
      clear_logs();
      csr_write(8'h03);
      wait_idle();
      check("R3 chain stops at end mark", n_xfer, 3);
      check("R1 four reads per descriptor", rd_cnt, 12);
      check("R1 desc A pci addr", lg_padr[0], 32'hA000_0000);
      check("R1 desc A local addr", lg_ladr[0], 32'h0000_0A00);
      check("R1 desc A count", lg_cnt[0], 32'h10);
      check("R3 desc A pci-to-local", {31'd0, lg_l2p[0]}, 0);
      check("R2 desc B fetched from PCI space", lg_padr[1], 32'hB000_0000);
      check("R2 desc B count", lg_cnt[1], 32'h20);
      check("R3 desc B local-to-pci", {31'd0, lg_l2p[1]}, 1);
      check("R2 desc C fetched from local space", lg_ladr[2], 32'h0000_0C00);
      check("R7 no write-back when off", wr_cnt, 0);
      check("R7 count preserved", lmem[50], 32'h30);
      check("R9 terminal-count irq on local pin", {30'd0, irq_pci, irq_local}, 1);
      repeat (5) @(negedge clk);
      check("R9 irq sticky", {31'd0, irq_local}, 1);
      csr_write(8'h09);
      check("R9 irq cleared by bit 3", {30'd0, irq_pci, irq_local}, 0);
   endtask

   task automatic t_clrcnt();
      mv_delay = 0;
      mode_write(32'h0001_0200);
      load_chain();
      clear_logs();
      csr_write(8'h03);
      wait_idle();
      check("R7 three write-backs", wr_cnt, 3);
      check("R7 desc A count cleared", lmem[18], 0);
      check("R7 desc B count cleared", pmem[34], 0);
      check("R7 desc C count cleared", lmem[50], 0);
      check("R7 link untouched", lmem[19], 32'h81);
      check("R7 transfers unchanged", n_xfer, 3);
      csr_write(8'h09);
   endtask

   task automatic t_route();
      mv_delay = 0;
      mode_write(32'h0002_0400);
      dir_write(2'd3, 32'h0000_0000);
      clear_logs();
      csr_write(8'h03);
      wait_idle();
      check("R10 done irq on PCI pin", {30'd0, irq_pci, irq_local}, 2);
      mode_write(32'h0000_0400);
      check("R10 irq moves to local pin", {30'd0, irq_pci, irq_local}, 1);
      csr_write(8'h09);
      check("R9 done irq cleared", {30'd0, irq_pci, irq_local}, 0);
   endtask

   task automatic t_busy();
      mv_delay = 10;
      mode_write(32'h0);
      clear_logs();
      csr_write(8'h03);
      repeat (2) @(negedge clk);
      check("R6 done low while busy", {31'd0, csr_status[4]}, 0);
      csr_write(8'h03);
      wait_idle();
      repeat (3) @(negedge clk);
      check("R5 start while busy ignored", n_xfer, 1);
      check("R6 done back high", {31'd0, csr_status[4]}, 1);
   endtask

   task automatic t_abort();
      mv_delay = 30;
      mode_write(32'h0000_0200);
      load_chain();
      clear_logs();
      csr_write(8'h03);
      for (int i = 0; i < 200; i++) begin
         if (xfer_req) break;
         @(negedge clk);
      end
      csr_write(8'h05);
      check("R11 still busy until handshake ends", {31'd0, csr_status[4]}, 0);
      wait_idle();
      repeat (5) @(negedge clk);
      check("R11 only the current transfer", n_xfer, 1);
      check("R11 no further descriptor reads", rd_cnt, 4);
      check("R11 done after abort", {24'd0, csr_status}, 32'h11);
      clear_logs();
      csr_write(8'h05);
      repeat (5) @(negedge clk);
      check("R11 abort while idle no effect", n_xfer + rd_cnt, 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct();
      t_no_enable();
      t_chain();
      t_clrcnt();
      t_route();
      t_busy();
      t_abort();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule